// File: doc/BRIEF.md
# Receive Address Filter with Automatic Acknowledgement

This block sits behind an IEEE 802.15.4 receive modem. It watches the MPDU octet stream of each incoming frame, decodes the frame control field and the destination addressing fields, and compares them with the node's configured PAN identifier, 16-bit short address and 64-bit extended address. A frame that passes the filter and has a good checksum raises a single-cycle accept strobe once the frame has ended. A frame that fails the filter leaves the block listening again, with no strobe.

When an accepted data or MAC command frame asks for an acknowledgement and was not sent to the broadcast short address, the block builds the acknowledgement itself. It counts a fixed number of symbol ticks after the end of the frame and then streams the whole acknowledgement PPDU octet by octet. The stream holds the synchronisation header, the length octet, the two frame control octets and the echoed sequence number. The checksum engine downstream appends the two FCS octets after the octet flagged as last. The frame-pending bit of the acknowledgement is taken from a configuration input at the moment its octet leaves, so software can still change it while the header is on air.

Top module: `rxf_filter_ack`

## Requirements
- R1: For a frame that qualifies for an acknowledgement, `ack_tx_start` pulses in the clock cycle after the edge that takes in the TURN_SYMS-th (default 12) `sym_tick` counted from the edge after the one that took in `rx_eof`.
- R2: The acknowledgement stream is nine octets: 0x00, 0x00, 0x00, 0x00, 0xA7, 0x05, frame-control low, 0x00, sequence number. Octet 0 comes with `ack_tx_start`, and octet k comes exactly 2·k symbol ticks later. `ack_last` is high only with octet 8.
- R3: The frame-control low octet is 0x02 with bit 4 set to the value of `cfg_frame_pending` sampled when that octet is issued. A change made after the start of the acknowledgement, but before that octet, is carried.
- R4: A frame whose destination short address is 0xFFFF is accepted but never acknowledged, even when frame-control bit 5 (acknowledgement request) is set.
- R5: A frame with a destination is dropped unless its destination PAN (octets 3 and 4, low octet first) equals `cfg_pan_id` or is 0xFFFF.
- R6: The destination address must equal the short address (destination mode bits 11:10 = 2'b10, 2 octets) or the extended address (mode 2'b11, 8 octets, least significant octet first).
- R7: A beacon (frame type bits 2:0 = 0) with no destination (mode 2'b00) is accepted and never acknowledged. Any other frame type with no destination is dropped.
- R8: `frame_accept` is a one-cycle pulse in the cycle after `rx_eof`. It fires only when the filter passes and `rx_fcs_ok` is high with `rx_eof`.
- R9: No acknowledgement is sent when the checksum is bad, when bit 5 is clear, or when the frame type is not data (1) or MAC command (3).
- R10: A frame is dropped when its type is 2 or above 3, when its destination mode is 2'b01, or when it has fewer octets than its header plus two FCS octets. A frame exactly that long is accepted.
- R11: From the accept of an acknowledged frame until the last acknowledgement octet's period ends, incoming frames are ignored: they cause no accept and no second acknowledgement.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pan_id | input | 16 | Node PAN identifier |
| cfg_short_addr | input | 16 | Node short address |
| cfg_ext_addr | input | 64 | Node extended address |
| cfg_frame_pending | input | 1 | Frame-pending value for acknowledgements |
| sym_tick | input | 1 | One-cycle strobe per symbol period |
| rx_sof | input | 1 | Start-of-frame strobe, before the first octet |
| rx_valid | input | 1 | `rx_byte` carries an MPDU octet |
| rx_byte | input | 8 | Received octet |
| rx_eof | input | 1 | End-of-frame strobe, after the last FCS octet |
| rx_fcs_ok | input | 1 | Checksum verdict, valid with `rx_eof` |
| frame_accept | output | 1 | Accepted-frame interrupt pulse |
| ack_tx_start | output | 1 | Acknowledgement transmission request |
| ack_valid | output | 1 | `ack_octet` carries an acknowledgement octet |
| ack_octet | output | 8 | Acknowledgement PPDU octet |
| ack_last | output | 1 | Final octet before the appended FCS |

## Verification
The bench builds the block with its default parameters: a 12-symbol turnaround, 2 symbols per octet and a 127-octet frame limit. It drives one symbol tick every four clocks, so a complete acknowledgement takes about 120 clocks. These values make the exact turnaround count, the spacing of every octet and a late frame-pending change before the frame-control octet directly observable. Frames of exactly header-plus-FCS length and one octet shorter probe the length boundary. A second frame sent during the turnaround shows that busy periods are ignored.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam logic [7:0] SFD_OCTET        = 8'hA7;
    localparam int         SHR_ZERO_OCTETS  = 4;
    localparam int         ACK_MPDU_OCTETS  = 5;
    localparam int         ACK_STREAM_OCTETS = SHR_ZERO_OCTETS + 2 + ACK_MPDU_OCTETS - 2;

    localparam logic [2:0] FT_BEACON = 3'd0;
    localparam logic [2:0] FT_DATA   = 3'd1;
    localparam logic [2:0] FT_CMD    = 3'd3;

    typedef enum logic [1:0] {
        AM_NONE  = 2'b00,
        AM_RSVD  = 2'b01,
        AM_SHORT = 2'b10,
        AM_EXT   = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        AQ_IDLE,
        AQ_WAIT,
        AQ_SEND
    } ackq_e;

    typedef struct packed {
        logic       done;
        logic       accept;
        logic       ack;
        logic [7:0] seq;
    } verdict_t;

    // MPDU header octets before the payload, for a given destination mode
    function automatic logic [4:0] hdr_octets(amode_e m);
        case (m)
            AM_SHORT: return 5'd7;
            AM_EXT:   return 5'd13;
            default:  return 5'd3;
        endcase
    endfunction

    // Octet k of the acknowledgement stream (FCS excluded)
    function automatic logic [7:0] ack_stream_byte(logic [3:0] k, logic pend, logic [7:0] seq);
        if (k < 4'(SHR_ZERO_OCTETS)) return 8'h00;
        case (k)
            4'd4:    return SFD_OCTET;
            4'd5:    return 8'(ACK_MPDU_OCTETS);
            4'd6:    return {3'b000, pend, 4'b0010};
            4'd7:    return 8'h00;
            default: return seq;
        endcase
    endfunction

endpackage

// File: rtl/rxf_parser.sv
module rxf_parser
    import rxf_pkg::*;
#(
    parameter int MAX_OCTETS = 127
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eof,
    input  logic        rx_fcs_ok,
    input  logic [15:0] cfg_pan,
    input  logic [15:0] cfg_short,
    input  logic [63:0] cfg_ext,
    output verdict_t    verdict
);
    localparam int CW = $clog2(MAX_OCTETS + 1);

    logic          in_frame;
    logic [CW-1:0] cnt;
    logic [2:0]    ftype;
    logic          ack_req;
    amode_e        dmode;
    logic [7:0]    seq;
    logic          pan_eq, pan_ff, adr_eq, adr_ff;

    logic          dst_present, in_pan, in_addr;
    logic [CW-1:0] rel, addr_len, need_len;
    logic [7:0]    pan_exp, adr_exp;
    logic          bcast, type_ok, fmt_ok, addr_ok, pass, ackable;

    always_comb begin
        dst_present = (dmode == AM_SHORT) || (dmode == AM_EXT);
        addr_len    = (dmode == AM_EXT) ? CW'(8) : ((dmode == AM_SHORT) ? CW'(2) : '0);
        rel         = cnt - CW'(5);
        in_pan      = dst_present && ((cnt == CW'(3)) || (cnt == CW'(4)));
        in_addr     = dst_present && (cnt >= CW'(5)) && (rel < addr_len);
        pan_exp     = cnt[0] ? cfg_pan[7:0] : cfg_pan[15:8];
        adr_exp     = (dmode == AM_EXT) ? cfg_ext[{rel[2:0], 3'b000} +: 8]
                    : (rel[0] ? cfg_short[15:8] : cfg_short[7:0]);

        need_len    = CW'(hdr_octets(dmode)) + CW'(2);
        bcast       = (dmode == AM_SHORT) && adr_ff;
        type_ok     = (ftype == FT_BEACON) || (ftype == FT_DATA) || (ftype == FT_CMD);
        fmt_ok      = type_ok && (dmode != AM_RSVD) && (cnt >= need_len);
        addr_ok     = dst_present ? ((pan_eq || pan_ff) && (adr_eq || bcast))
                                  : (ftype == FT_BEACON);
        pass        = fmt_ok && addr_ok && rx_fcs_ok;
        ackable     = pass && ack_req && ((ftype == FT_DATA) || (ftype == FT_CMD)) && !bcast;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            cnt      <= '0;
            ftype    <= '0;
            ack_req  <= 1'b0;
            dmode    <= AM_NONE;
            seq      <= '0;
            pan_eq   <= 1'b1;
            pan_ff   <= 1'b1;
            adr_eq   <= 1'b1;
            adr_ff   <= 1'b1;
            verdict  <= '0;
        end else begin
            verdict <= '0;
            if (en && rx_sof) begin
                in_frame <= 1'b1;
                cnt      <= '0;
                dmode    <= AM_NONE;
                pan_eq   <= 1'b1;
                pan_ff   <= 1'b1;
                adr_eq   <= 1'b1;
                adr_ff   <= 1'b1;
            end else if (in_frame && rx_eof) begin
                in_frame       <= 1'b0;
                verdict.done   <= 1'b1;
                verdict.accept <= pass;
                verdict.ack    <= ackable;
                verdict.seq    <= seq;
            end else if (in_frame && rx_valid) begin
                if (cnt != CW'(MAX_OCTETS)) cnt <= cnt + 1'b1;
                if (cnt == '0) begin
                    ftype   <= rx_byte[2:0];
                    ack_req <= rx_byte[5];
                end
                if (cnt == CW'(1)) dmode <= amode_e'(rx_byte[3:2]);
                if (cnt == CW'(2)) seq <= rx_byte;
                if (in_pan) begin
                    pan_eq <= pan_eq && (rx_byte == pan_exp);
                    pan_ff <= pan_ff && (rx_byte == 8'hFF);
                end
                if (in_addr) begin
                    adr_eq <= adr_eq && (rx_byte == adr_exp);
                    adr_ff <= adr_ff && (rx_byte == 8'hFF);
                end
            end
        end
    end

endmodule

// File: rtl/rxf_ack_seq.sv
module rxf_ack_seq
    import rxf_pkg::*;
#(
    parameter int TURN_SYMS      = 12,
    parameter int SYMS_PER_OCTET = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_tick,
    input  logic       ack_go,
    input  logic [7:0] ack_seq,
    input  logic       cfg_pending,
    output logic       busy,
    output logic       tx_start,
    output logic       tx_valid,
    output logic [7:0] tx_octet,
    output logic       tx_last
);
    localparam int         TW       = $clog2(TURN_SYMS + 1);
    localparam int         OW       = $clog2(SYMS_PER_OCTET + 1);
    localparam logic [3:0] LAST_IDX = 4'(ACK_STREAM_OCTETS - 1);

    ackq_e         state;
    logic [TW-1:0] tcnt;
    logic [OW-1:0] ocnt;
    logic [3:0]    idx;
    logic [3:0]    nidx;
    logic [7:0]    seq_q;

    assign busy = (state != AQ_IDLE);
    assign nidx = idx + 4'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= AQ_IDLE;
            tcnt     <= '0;
            ocnt     <= '0;
            idx      <= '0;
            seq_q    <= '0;
            tx_start <= 1'b0;
            tx_valid <= 1'b0;
            tx_octet <= '0;
            tx_last  <= 1'b0;
        end else begin
            tx_start <= 1'b0;
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            case (state)
                AQ_IDLE: if (ack_go) begin
                    seq_q <= ack_seq;
                    tcnt  <= sym_tick ? TW'(1) : '0;
                    state <= AQ_WAIT;
                end
                AQ_WAIT: if (sym_tick) begin
                    if (tcnt == TW'(TURN_SYMS - 1)) begin
                        state    <= AQ_SEND;
                        idx      <= '0;
                        ocnt     <= '0;
                        tx_start <= 1'b1;
                        tx_valid <= 1'b1;
                        tx_octet <= ack_stream_byte(4'd0, cfg_pending, seq_q);
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                AQ_SEND: if (sym_tick) begin
                    if (ocnt == OW'(SYMS_PER_OCTET - 1)) begin
                        ocnt <= '0;
                        if (idx == LAST_IDX) begin
                            state <= AQ_IDLE;
                        end else begin
                            idx      <= nidx;
                            tx_valid <= 1'b1;
                            tx_octet <= ack_stream_byte(nidx, cfg_pending, seq_q);
                            tx_last  <= (nidx == LAST_IDX);
                        end
                    end else begin
                        ocnt <= ocnt + 1'b1;
                    end
                end
                default: state <= AQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rxf_filter_ack.sv
module rxf_filter_ack
    import rxf_pkg::*;
#(
    parameter int MAX_OCTETS     = 127,
    parameter int TURN_SYMS      = 12,
    parameter int SYMS_PER_OCTET = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cfg_pan_id,
    input  logic [15:0] cfg_short_addr,
    input  logic [63:0] cfg_ext_addr,
    input  logic        cfg_frame_pending,
    input  logic        sym_tick,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eof,
    input  logic        rx_fcs_ok,
    output logic        frame_accept,
    output logic        ack_tx_start,
    output logic        ack_valid,
    output logic [7:0]  ack_octet,
    output logic        ack_last
);
    verdict_t verdict;
    logic     ack_go;
    logic     ack_busy;
    logic     parse_en;

    assign ack_go       = verdict.done && verdict.ack;
    assign parse_en     = !(ack_busy || ack_go);
    assign frame_accept = verdict.done && verdict.accept;

    rxf_parser #(.MAX_OCTETS(MAX_OCTETS)) u_parser (
        .clk       (clk),
        .rst       (rst),
        .en        (parse_en),
        .rx_sof    (rx_sof),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_eof    (rx_eof),
        .rx_fcs_ok (rx_fcs_ok),
        .cfg_pan   (cfg_pan_id),
        .cfg_short (cfg_short_addr),
        .cfg_ext   (cfg_ext_addr),
        .verdict   (verdict)
    );

    rxf_ack_seq #(
        .TURN_SYMS      (TURN_SYMS),
        .SYMS_PER_OCTET (SYMS_PER_OCTET)
    ) u_ack (
        .clk         (clk),
        .rst         (rst),
        .sym_tick    (sym_tick),
        .ack_go      (ack_go),
        .ack_seq     (verdict.seq),
        .cfg_pending (cfg_frame_pending),
        .busy        (ack_busy),
        .tx_start    (ack_tx_start),
        .tx_valid    (ack_valid),
        .tx_octet    (ack_octet),
        .tx_last     (ack_last)
    );

endmodule

// File: rtl/rxf_filter_ack_chk.sv
module rxf_filter_ack_chk #(
    parameter int TURN_SYMS = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       sym_tick,
    input logic       cfg_frame_pending,
    input logic       frame_accept,
    input logic       ack_tx_start,
    input logic       ack_valid,
    input logic [7:0] ack_octet,
    input logic       ack_last
);
    logic [7:0] tk;
    logic [3:0] n_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            tk    <= '0;
            n_out <= '0;
        end else begin
            if (frame_accept)                  tk <= {7'd0, sym_tick};
            else if (sym_tick && tk != 8'hFF)  tk <= tk + 8'd1;
            if (ack_tx_start)                  n_out <= 4'd1;
            else if (ack_valid)                n_out <= n_out + 4'd1;
        end
    end

    p_turnaround_r1: assert property (@(posedge clk) disable iff (rst)
        ack_tx_start |-> (tk == 8'(TURN_SYMS)));

    p_first_octet_r2: assert property (@(posedge clk) disable iff (rst)
        ack_tx_start |-> (ack_valid && ack_octet == 8'h00));

    p_last_flag_r2: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_tx_start) |-> (ack_last == (n_out == 4'd8)));

    p_pending_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_tx_start && n_out == 4'd6)
            |-> (ack_octet == {3'b000, $past(cfg_frame_pending), 4'b0010}));

    p_accept_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        frame_accept |=> !frame_accept);

    p_quiet_while_ack_r11: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !frame_accept);

endmodule

bind rxf_filter_ack rxf_filter_ack_chk #(.TURN_SYMS(TURN_SYMS)) u_chk (
    .clk               (clk),
    .rst               (rst),
    .sym_tick          (sym_tick),
    .cfg_frame_pending (cfg_frame_pending),
    .frame_accept      (frame_accept),
    .ack_tx_start      (ack_tx_start),
    .ack_valid         (ack_valid),
    .ack_octet         (ack_octet),
    .ack_last          (ack_last)
);

// File: tb/rxf_filter_ack_tb.sv
`timescale 1ns/1ps
module rxf_filter_ack_tb_top;

    localparam logic [15:0] MY_PAN   = 16'h1234;
    localparam logic [15:0] MY_SHORT = 16'hBEEF;
    localparam logic [63:0] MY_EXT   = 64'h0102030405060708;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_frame_pending = 1'b0;
    logic        sym_tick = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_fcs_ok = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        frame_accept, ack_tx_start, ack_valid, ack_last;
    logic [7:0]  ack_octet;

    always #5 clk = ~clk;

    rxf_filter_ack dut_i (
        .clk (clk), .rst (rst),
        .cfg_pan_id (MY_PAN), .cfg_short_addr (MY_SHORT), .cfg_ext_addr (MY_EXT),
        .cfg_frame_pending (cfg_frame_pending),
        .sym_tick (sym_tick),
        .rx_sof (rx_sof), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .rx_eof (rx_eof), .rx_fcs_ok (rx_fcs_ok),
        .frame_accept (frame_accept), .ack_tx_start (ack_tx_start),
        .ack_valid (ack_valid), .ack_octet (ack_octet), .ack_last (ack_last)
    );

    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    // symbol tick every fourth clock
    int div = 0;
    always @(negedge clk) begin
        if (rst) begin div = 0; sym_tick = 1'b0; end
        else begin div = (div + 1) % 4; sym_tick = (div == 0); end
    end

    // output monitor, sampled 2 ns after the rising edge
    int samp = 0, tk = 0, eof_samp = -1, acc_samp = -1;
    int acc_n = 0, st_n = 0, st_tk = -1, cap_n = 0;
    logic [7:0] cap [16];
    int         cap_tk [16];
    logic       cap_last [16];
    always begin
        @(posedge clk); #2;
        samp++;
        if (rx_eof) begin tk = 0; eof_samp = samp; end
        else if (sym_tick) tk++;
        if (frame_accept) begin acc_n++; acc_samp = samp; end
        if (ack_tx_start) begin st_n++; st_tk = tk; end
        if (ack_valid && cap_n < 16) begin
            cap[cap_n] = ack_octet; cap_tk[cap_n] = tk; cap_last[cap_n] = ack_last; cap_n++;
        end
    end

    logic [7:0] fr [32];
    int         fr_n = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        end
    endtask

    function automatic logic [7:0] exp_ack(int k, logic p, logic [7:0] s);
        if (k < 4) return 8'h00;
        if (k == 4) return 8'hA7;
        if (k == 5) return 8'h05;
        if (k == 6) return {3'b000, p, 4'b0010};
        if (k == 7) return 8'h00;
        return s;
    endfunction

    task automatic mk_short(input logic [7:0] fc0, input logic [7:0] sq,
                            input logic [15:0] pan, input logic [15:0] dst);
        fr[0] = fc0; fr[1] = 8'h88; fr[2] = sq;
        fr[3] = pan[7:0]; fr[4] = pan[15:8]; fr[5] = dst[7:0]; fr[6] = dst[15:8];
        fr[7] = 8'hCD; fr[8] = 8'hAB; fr[9] = 8'h11; fr[10] = 8'h22;
        fr_n = 11;
    endtask

    task automatic mk_ext(input logic [7:0] sq, input logic [63:0] dst);
        fr[0] = 8'h61; fr[1] = 8'h8C; fr[2] = sq; fr[3] = MY_PAN[7:0]; fr[4] = MY_PAN[15:8];
        for (int i = 0; i < 8; i++) fr[5+i] = dst[8*i +: 8];
        fr[13] = 8'hCD; fr[14] = 8'hAB; fr[15] = 8'h11; fr[16] = 8'h22;
        fr_n = 17;
    endtask

    task automatic mk_nodst(input logic [7:0] fc0, input logic [7:0] sq);
        fr[0] = fc0; fr[1] = 8'h80; fr[2] = sq; fr[3] = 8'h34; fr[4] = 8'h12;
        fr[5] = 8'hCD; fr[6] = 8'hAB; fr[7] = 8'hAA; fr[8] = 8'hBB; fr[9] = 8'h11; fr[10] = 8'h22;
        fr_n = 11;
    endtask

    task automatic clear_mon();
        @(negedge clk);
        acc_n = 0; st_n = 0; st_tk = -1; cap_n = 0; acc_samp = -1;
    endtask

    task automatic send(input logic fcs);
        @(negedge clk); rx_sof = 1'b1;
        @(negedge clk); rx_sof = 1'b0;
        for (int i = 0; i < fr_n; i++) begin
            rx_valid = 1'b1; rx_byte = fr[i];
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_eof = 1'b1; rx_fcs_ok = fcs;
        @(negedge clk);
        rx_eof = 1'b0; rx_fcs_ok = 1'b0;
    endtask

    task automatic settle();
        repeat (200) @(negedge clk);
    endtask

    task automatic expect_ack(input string tag, input logic [7:0] sq, input logic p);
        chk({tag, " R1 start count"}, st_n, 1);
        chk({tag, " R1 turnaround ticks"}, st_tk, 12);
        chk({tag, " R2 octet count"}, cap_n, 9);
        for (int k = 0; k < 9; k++) begin
            chk($sformatf("%s R2 octet %0d", tag, k), cap[k], exp_ack(k, p, sq));
            chk($sformatf("%s R2 spacing %0d", tag, k), cap_tk[k], 12 + 2*k);
            chk($sformatf("%s R2 last %0d", tag, k), cap_last[k], (k == 8) ? 1 : 0);
        end
    endtask

    task automatic expect_no_ack(input string tag);
        chk({tag, " start count"}, st_n, 0);
        chk({tag, " octet count"}, cap_n, 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R12 frame_accept", frame_accept, 0);
        chk("R12 ack_tx_start", ack_tx_start, 0);
        chk("R12 ack_valid", ack_valid, 0);
        chk("R12 ack_octet", ack_octet, 0);
        chk("R12 ack_last", ack_last, 0);
    endtask

    task automatic t_unicast_ack();
        clear_mon(); mk_short(8'h61, 8'h5A, MY_PAN, MY_SHORT); send(1'b1); settle();
        chk("R8 accept count", acc_n, 1);
        chk("R8 accept one cycle after eof", acc_samp, eof_samp);
        expect_ack("unicast", 8'h5A, 1'b0);
    endtask

    task automatic t_late_pending();
        clear_mon(); cfg_frame_pending = 1'b0;
        mk_short(8'h63, 8'hC3, MY_PAN, MY_SHORT); send(1'b1);
        while (tk < 18) @(negedge clk);
        cfg_frame_pending = 1'b1;
        settle();
        chk("R3 pending octet", cap[6], 8'h12);
        expect_ack("R3 late pending", 8'hC3, 1'b1);
        cfg_frame_pending = 1'b0;
    endtask

    task automatic t_broadcast();
        clear_mon(); mk_short(8'h61, 8'h01, MY_PAN, 16'hFFFF); send(1'b1); settle();
        chk("R4 broadcast accepted", acc_n, 1);
        expect_no_ack("R4 broadcast");
    endtask

    task automatic t_pan();
        clear_mon(); mk_short(8'h61, 8'h02, 16'h4321, MY_SHORT); send(1'b1); settle();
        chk("R5 foreign PAN accept", acc_n, 0);
        expect_no_ack("R5 foreign PAN");
        clear_mon(); mk_short(8'h61, 8'h03, 16'hFFFF, MY_SHORT); send(1'b1); settle();
        chk("R5 broadcast PAN accept", acc_n, 1);
        expect_ack("R5 broadcast PAN", 8'h03, 1'b0);
    endtask

    task automatic t_addr();
        clear_mon(); mk_short(8'h61, 8'h04, MY_PAN, 16'hBEEE); send(1'b1); settle();
        chk("R6 short mismatch accept", acc_n, 0);
        expect_no_ack("R6 short mismatch");
        clear_mon(); mk_ext(8'h05, MY_EXT); send(1'b1); settle();
        chk("R6 ext match accept", acc_n, 1);
        expect_ack("R6 ext match", 8'h05, 1'b0);
        clear_mon(); mk_ext(8'h06, MY_EXT ^ 64'h0000_0100_0000_0000); send(1'b1); settle();
        chk("R6 ext mismatch accept", acc_n, 0);
        expect_no_ack("R6 ext mismatch");
    endtask

    task automatic t_nodst();
        clear_mon(); mk_nodst(8'h20, 8'h07); send(1'b1); settle();
        chk("R7 beacon accept", acc_n, 1);
        expect_no_ack("R7 beacon");
        clear_mon(); mk_nodst(8'h61, 8'h08); send(1'b1); settle();
        chk("R7 data without destination accept", acc_n, 0);
        expect_no_ack("R7 data without destination");
    endtask

    task automatic t_fcs_and_req();
        clear_mon(); mk_short(8'h61, 8'h09, MY_PAN, MY_SHORT); send(1'b0); settle();
        chk("R8 bad FCS accept", acc_n, 0);
        expect_no_ack("R9 bad FCS");
        clear_mon(); mk_short(8'h41, 8'h0A, MY_PAN, MY_SHORT); send(1'b1); settle();
        chk("R9 no request accept", acc_n, 1);
        expect_no_ack("R9 no request");
        clear_mon(); mk_short(8'h60, 8'h0B, MY_PAN, MY_SHORT); send(1'b1); settle();
        chk("R9 beacon with request accept", acc_n, 1);
        expect_no_ack("R9 beacon with request");
    endtask

    task automatic t_format();
        clear_mon(); mk_short(8'h61, 8'h0C, MY_PAN, MY_SHORT); fr_n = 8; send(1'b1); settle();
        chk("R10 short by one accept", acc_n, 0);
        expect_no_ack("R10 short by one");
        clear_mon(); mk_short(8'h61, 8'h0D, MY_PAN, MY_SHORT); fr_n = 9; send(1'b1); settle();
        chk("R10 exact length accept", acc_n, 1);
        expect_ack("R10 exact length", 8'h0D, 1'b0);
        clear_mon(); mk_short(8'h65, 8'h0E, MY_PAN, MY_SHORT); send(1'b1); settle();
        chk("R10 reserved type accept", acc_n, 0);
        clear_mon(); mk_short(8'h62, 8'h0F, MY_PAN, MY_SHORT); send(1'b1); settle();
        chk("R10 ack type accept", acc_n, 0);
        clear_mon(); mk_short(8'h61, 8'h10, MY_PAN, MY_SHORT); fr[1] = 8'h84; send(1'b1); settle();
        chk("R10 reserved mode accept", acc_n, 0);
        expect_no_ack("R10 reserved mode");
    endtask

    task automatic t_busy();
        clear_mon(); mk_short(8'h61, 8'h11, MY_PAN, MY_SHORT); send(1'b1);
        while (tk < 3) @(negedge clk);
        mk_short(8'h61, 8'h22, MY_PAN, MY_SHORT); send(1'b1);
        settle();
        chk("R11 accept count", acc_n, 1);
        chk("R11 start count", st_n, 1);
        chk("R11 octet count", cap_n, 9);
        chk("R11 echoed sequence", cap[8], 8'h11);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_unicast_ack();
        t_late_pending();
        t_broadcast();
        t_pan();
        t_addr();
        t_nodst();
        t_fcs_and_req();
        t_format();
        t_busy();
        summary();
        $finish;
    end

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        summary();
        $finish;
    end

endmodule